// File: doc/BRIEF.md
# Data-Controlled Dynamic Upsampler

This block expands a stream of signed fixed-point samples by a factor that arrives with each sample. Every accepted (sample, factor) pair produces as many output samples as the factor says, so the output rate changes from one input to the next. A factor of zero consumes the sample and produces nothing.

The gaps are filled according to a fill-mode input. Three policies are available: zero insertion, repetition of the sample, and linear interpolation from the previously accepted sample to the current one. In the interpolation policy, the per-output step is the difference between the two samples divided by the factor. A multi-cycle sequential divider computes this step before the first output of the group is offered. The output is widened by `FRAC_W` fractional bits, so interpolated points keep their sub-integer part.

Both sides use valid/ready handshakes. While an output group is outstanding, the input is not accepted.

Top module: `dyn_upsampler`

## Requirements
- R1: An accepted pair with factor N (1 to 2^FACTOR_W-1) produces exactly N output handshakes. The next pair is accepted only after the last of them.
- R2: A pair with factor 0 is consumed and produces no output. `in_ready` is high again in the following cycle.
- R3: With fill mode 2'b00 (zero insertion), output 1 of a group is the sample and outputs 2..N are zero.
- R4: With fill mode 2'b01 (repeat), every output of the group equals the sample. The unused code 2'b11 also behaves as repeat.
- R5: With fill mode 2'b10 (linear), output k of N, for k<N, is P·2^FRAC_W + k·S. P is the previous sample. S is (C−P)·2^FRAC_W / N truncated toward zero, where C is the current sample. Output N equals C·2^FRAC_W.
- R6: Every `out_sample` value is the two's-complement sample value scaled by 2^FRAC_W. This holds in every mode.
- R7: The previous sample is the last accepted sample, including pairs with factor 0. Reset clears it to zero.
- R8: `in_ready` is high only when no group is pending. It is never high in the same cycle as `out_valid`.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_sample` stays unchanged in the next cycle.
- R10: In linear mode, no output is offered while the step division is in progress.
- R11: The fill mode is captured when the pair is accepted. Changes on `fill_mode` during a pending group have no effect on that group.
- R12: Synchronous active-high reset abandons any pending group. After the reset edge, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_mode | input | 2 | Fill policy: 00 zero, 01 repeat, 10 linear, 11 repeat |
| in_valid | input | 1 | Input pair valid |
| in_ready | output | 1 | Input pair accepted when high together with in_valid |
| in_sample | input | DATA_W | Signed input sample |
| in_factor | input | FACTOR_W | Unsigned expansion factor for this sample |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream accepts the output sample |
| out_sample | output | DATA_W+FRAC_W | Signed output, scaled by 2^FRAC_W |

## Verification
The bench builds the block with DATA_W=6, FACTOR_W=4 and FRAC_W=4. This small configuration lets a single run sweep every factor from 0 to 15 in all four mode codes. The samples are spread across the whole signed 6-bit range, so positive, negative and zero differences all reach the divider. Expected outputs come from integer arithmetic in the bench, with a running previous-sample value. Periodic output stalls and input gaps exercise the handshake, and the fill-mode input is scrambled while groups are pending. A reset in the middle of a group, followed by an interpolated pair, shows that the pending group is dropped and that the previous sample returns to zero.

// File: rtl/usmp_pkg.sv
package usmp_pkg;

  typedef enum logic [1:0] {
    FILL_ZERO   = 2'b00,
    FILL_REPEAT = 2'b01,
    FILL_LINEAR = 2'b10,
    FILL_ALT    = 2'b11
  } fill_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_DIVW = 2'b01,
    ST_EMIT = 2'b10
  } grp_state_t;

endpackage

// File: rtl/usmp_divider.sv
module usmp_divider #(
  parameter int NUM_W = 25,
  parameter int DEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic             done,
  output logic [NUM_W-1:0] quot
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] q_r;
  logic [DEN_W-1:0] r_r;
  logic [DEN_W-1:0] d_r;
  logic [CNT_W-1:0] cnt_r;

  logic [DEN_W:0] shifted;
  logic [DEN_W:0] trial;
  logic           fits;

  // one restoring step: bring down the next numerator bit
  assign shifted = {r_r, q_r[NUM_W-1]};
  assign trial   = shifted - {1'b0, d_r};
  assign fits    = shifted >= {1'b0, d_r};

  always_ff @(posedge clk) begin
    if (rst) begin
      q_r   <= '0;
      r_r   <= '0;
      d_r   <= '0;
      cnt_r <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        q_r   <= num;
        r_r   <= '0;
        d_r   <= den;
        cnt_r <= CNT_W'(NUM_W);
        busy  <= 1'b1;
      end else if (busy) begin
        r_r   <= fits ? trial[DEN_W-1:0] : shifted[DEN_W-1:0];
        q_r   <= {q_r[NUM_W-2:0], fits};
        cnt_r <= cnt_r - 1'b1;
        if (cnt_r == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quot = q_r;

endmodule

// File: rtl/usmp_ctrl.sv
module usmp_ctrl
  import usmp_pkg::*;
#(
  parameter int FACTOR_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [FACTOR_W-1:0] in_factor,
  input  logic                linear_sel,
  input  logic                div_done,
  input  logic                out_ready,
  output logic                in_ready,
  output logic                out_valid,
  output logic                accept,
  output logic                zero_n,
  output logic                div_start,
  output logic                load_step,
  output logic                grp_last,
  output logic [FACTOR_W-1:0] idx,
  output logic [FACTOR_W-1:0] grp_n
);
  grp_state_t state;
  logic       out_fire;

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_EMIT);
  assign accept    = in_valid && in_ready;
  assign zero_n    = (in_factor == '0);
  assign div_start = accept && !zero_n && linear_sel;
  assign load_step = (state == ST_DIVW) && div_done;
  assign out_fire  = out_valid && out_ready;
  assign grp_last  = out_fire && (idx == grp_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      idx   <= '0;
      grp_n <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept && !zero_n) begin
            grp_n <= in_factor;
            idx   <= FACTOR_W'(1);
            state <= linear_sel ? ST_DIVW : ST_EMIT;
          end
        end
        ST_DIVW: begin
          if (div_done) state <= ST_EMIT;
        end
        ST_EMIT: begin
          if (out_fire) begin
            if (idx == grp_n) state <= ST_IDLE;
            else              idx   <= idx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/usmp_fill.sv
module usmp_fill
  import usmp_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int FACTOR_W = 8,
  parameter int FRAC_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     accept,
  input  logic                     zero_n,
  input  logic                     grp_last,
  input  logic                     load_step,
  input  logic [DATA_W-1:0]        in_sample,
  input  logic [1:0]               fill_mode,
  input  logic [FACTOR_W-1:0]      idx,
  input  logic [FACTOR_W-1:0]      grp_n,
  input  logic [DATA_W+FRAC_W:0]   quot,
  output logic                     linear_sel,
  output logic [DATA_W+FRAC_W:0]   div_num,
  output logic [DATA_W+FRAC_W-1:0] out_sample
);
  localparam int OUT_W  = DATA_W + FRAC_W;
  localparam int NUM_W  = DATA_W + 1 + FRAC_W;
  localparam int STEP_W = NUM_W + 1;
  localparam int P_W    = STEP_W + FACTOR_W + 1;

  // sample value scaled to the output fixed-point grid
  function automatic logic signed [OUT_W-1:0] scale_up(input logic signed [DATA_W-1:0] s);
    logic signed [OUT_W-1:0] w;
    w = OUT_W'(s);
    return w <<< FRAC_W;
  endfunction

  // interpolated point k: base scaled plus k steps
  function automatic logic signed [P_W-1:0] lerp_at(input logic signed [DATA_W-1:0] base,
                                                     input logic signed [STEP_W-1:0] st,
                                                     input logic [FACTOR_W-1:0] k);
    logic signed [P_W-1:0] b;
    logic signed [P_W-1:0] s;
    logic signed [P_W-1:0] kk;
    b  = P_W'(base);
    b  = b <<< FRAC_W;
    s  = P_W'(st);
    kk = P_W'({1'b0, k});
    return b + s * kk;
  endfunction

  logic signed [DATA_W-1:0] cur_q;
  logic signed [DATA_W-1:0] prev_q;
  fill_t                    mode_q;
  logic                     neg_q;
  logic signed [STEP_W-1:0] step_q;

  logic signed [DATA_W:0]   diff_w;
  logic [DATA_W:0]          mag_w;
  logic signed [P_W-1:0]    lerp_w;

  assign linear_sel = (fill_mode == FILL_LINEAR);
  assign diff_w     = {in_sample[DATA_W-1], in_sample} - {prev_q[DATA_W-1], prev_q};
  assign mag_w      = diff_w[DATA_W] ? (DATA_W+1)'(-diff_w) : diff_w;
  assign div_num    = {mag_w, {FRAC_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= '0;
      prev_q <= '0;
      mode_q <= FILL_ZERO;
      neg_q  <= 1'b0;
      step_q <= '0;
    end else begin
      if (accept) begin
        cur_q  <= in_sample;
        mode_q <= fill_t'(fill_mode);
        neg_q  <= diff_w[DATA_W];
        if (zero_n) prev_q <= in_sample;
      end else if (grp_last) begin
        prev_q <= cur_q;
      end
      if (load_step) begin
        step_q <= neg_q ? -$signed({1'b0, quot}) : $signed({1'b0, quot});
      end
    end
  end

  assign lerp_w = lerp_at(prev_q, step_q, idx);

  always_comb begin
    unique case (mode_q)
      FILL_ZERO:   out_sample = (idx == FACTOR_W'(1)) ? scale_up(cur_q) : '0;
      FILL_LINEAR: out_sample = (idx == grp_n) ? scale_up(cur_q) : lerp_w[OUT_W-1:0];
      default:     out_sample = scale_up(cur_q);
    endcase
  end

endmodule

// File: rtl/dyn_upsampler.sv
module dyn_upsampler
  import usmp_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int FACTOR_W = 8,
  parameter int FRAC_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [1:0]               fill_mode,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [DATA_W-1:0]        in_sample,
  input  logic [FACTOR_W-1:0]      in_factor,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [DATA_W+FRAC_W-1:0] out_sample
);
  localparam int OUT_W = DATA_W + FRAC_W;
  localparam int NUM_W = DATA_W + 1 + FRAC_W;

  // internal events, named for the checker
  logic                accept_w;
  logic                zero_n_w;
  logic                div_start_w;
  logic                div_busy_w;
  logic                div_done_w;
  logic                load_step_w;
  logic                grp_last_w;
  logic                linear_sel_w;
  logic [FACTOR_W-1:0] idx_w;
  logic [FACTOR_W-1:0] grp_n_w;
  logic [NUM_W-1:0]    div_num_w;
  logic [NUM_W-1:0]    quot_w;

  usmp_ctrl #(.FACTOR_W(FACTOR_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_factor (in_factor),
    .linear_sel(linear_sel_w),
    .div_done  (div_done_w),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .accept    (accept_w),
    .zero_n    (zero_n_w),
    .div_start (div_start_w),
    .load_step (load_step_w),
    .grp_last  (grp_last_w),
    .idx       (idx_w),
    .grp_n     (grp_n_w)
  );

  usmp_divider #(.NUM_W(NUM_W), .DEN_W(FACTOR_W)) u_div (
    .clk  (clk),
    .rst  (rst),
    .start(div_start_w),
    .num  (div_num_w),
    .den  (in_factor),
    .busy (div_busy_w),
    .done (div_done_w),
    .quot (quot_w)
  );

  usmp_fill #(.DATA_W(DATA_W), .FACTOR_W(FACTOR_W), .FRAC_W(FRAC_W)) u_fill (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept_w),
    .zero_n    (zero_n_w),
    .grp_last  (grp_last_w),
    .load_step (load_step_w),
    .in_sample (in_sample),
    .fill_mode (fill_mode),
    .idx       (idx_w),
    .grp_n     (grp_n_w),
    .quot      (quot_w),
    .linear_sel(linear_sel_w),
    .div_num   (div_num_w),
    .out_sample(out_sample)
  );

endmodule

// File: rtl/usmp_checker.sv
module usmp_checker #(
  parameter int FACTOR_W = 8,
  parameter int OUT_W    = 24
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                in_ready,
  input logic [FACTOR_W-1:0] in_factor,
  input logic                out_valid,
  input logic                out_ready,
  input logic [OUT_W-1:0]    out_sample,
  input logic                div_busy
);
  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_sample));

  // R8
  ready_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && out_valid));

  // R2
  zero_factor_idle_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && (in_factor == '0) |=> in_ready && !out_valid);

  // R1
  group_pending_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && (in_factor != '0) |=> !in_ready);

  // R10
  div_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    div_busy |-> !out_valid);

  // R12
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !out_valid && in_ready);

endmodule

bind dyn_upsampler usmp_checker #(.FACTOR_W(FACTOR_W), .OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_factor (in_factor),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_sample(out_sample),
  .div_busy  (div_busy_w)
);

// File: tb/test_dyn_upsampler.sv
module test_dyn_upsampler;
  localparam int DW  = 6;
  localparam int FW  = 4;
  localparam int FR  = 4;
  localparam int OW  = DW + FR;
  localparam int WD  = 190000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    fill_mode = 2'b00;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_sample = '0;
  logic [FW-1:0] in_factor = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [OW-1:0] out_sample;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;
  bit wd_hit  = 0;
  int prev_s  = 0;

  int    stim_s[$];
  int    stim_n[$];
  int    stim_m[$];
  int    exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  dyn_upsampler #(.DATA_W(DW), .FACTOR_W(FW), .FRAC_W(FR)) i_dyn_upsampler (
    .clk(clk), .rst(rst), .fill_mode(fill_mode),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .in_factor(in_factor),
    .out_valid(out_valid), .out_ready(out_ready), .out_sample(out_sample)
  );

  // R3 R4 R5 R6: expected output k of n, computed arithmetically
  function automatic int exp_val(int mode, int p, int c, int n, int k);
    int ps = p * (1 << FR);
    int cs = c * (1 << FR);
    int st;
    if (mode == 0) return (k == 1) ? cs : 0;
    if (mode == 2) begin
      if (k == n) return cs;
      st = (cs - ps) / n;
      return ps + k * st;
    end
    return cs;
  endfunction

  function automatic string mode_tag(int mode);
    if (mode == 0) return "R3";
    if (mode == 2) return "R5";
    return "R4";
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // R7: bench keeps its own previous-sample value
  task automatic push_expect(int s, int n, int m);
    for (int k = 1; k <= n; k++) begin
      exp_q.push_back(exp_val(m, prev_s, s, n, k));
      tag_q.push_back(mode_tag(m));
    end
    prev_s = s;
  endtask

  task automatic run_stim();
    int  idx  = 0;
    bit  sent = 0;
    bit  present;
    int  e;
    string t;
    while ((idx < stim_s.size() || exp_q.size() > 0) && !wd_hit) begin
      @(negedge clk);
      cyc++;
      if (cyc > WD) begin
        wd_hit = 1;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD);
        break;
      end
      if (sent) begin idx++; sent = 0; end
      // R8 R1: ready only with nothing outstanding
      check(in_ready == (exp_q.size() == 0), "R8", in_ready, exp_q.size() == 0);
      out_ready = ((cyc % 5) != 2);
      if (out_valid && exp_q.size() == 0) begin
        check(0, "R2", out_valid, 0);
      end else if (out_valid && out_ready) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check($signed(out_sample) == e, t, $signed(out_sample), e);
      end
      present = (idx < stim_s.size()) && ((cyc % 11) != 5);
      if (present) begin
        in_valid  = 1'b1;
        in_sample = stim_s[idx][DW-1:0];
        in_factor = stim_n[idx][FW-1:0];
        // R11: scramble the mode whenever no acceptance happens
        fill_mode = in_ready ? stim_m[idx][1:0] : 2'(cyc);
        if (in_ready) begin
          sent = 1;
          push_expect(stim_s[idx], stim_n[idx], stim_m[idx]);
        end
      end else begin
        in_valid  = 1'b0;
        fill_mode = 2'(cyc + 1);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    stim_s.delete(); stim_n.delete(); stim_m.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: state after reset
    check(out_valid == 1'b0, "R12", out_valid, 0);
    check(in_ready == 1'b1, "R12", in_ready, 1);
    rst = 1'b0;

    // sweep: every mode code, every factor, samples across the signed range
    for (int m = 0; m < 4; m++)
      for (int s = -32; s < 32; s += 3)
        for (int n = 0; n < (1 << FW); n++) begin
          stim_s.push_back((n % 2) ? s : -s - 1);
          stim_n.push_back(n);
          stim_m.push_back(m);
        end
    run_stim();

    // R2 R7: zero factor updates the previous sample for interpolation
    stim_s = '{-20, 13, 7};
    stim_n = '{3, 0, 5};
    stim_m = '{2, 2, 2};
    run_stim();

    // R12: reset in the middle of a repeat group
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_sample = 6'd5; in_factor = 4'd9; fill_mode = 2'b01;
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R12", out_valid, 0);
    check(in_ready == 1'b1, "R12", in_ready, 1);
    rst = 1'b0;
    prev_s = 0;

    // R7: previous sample cleared by reset -> 4 over 2 steps from 0 gives 2 then 4
    stim_s = '{4};
    stim_n = '{2};
    stim_m = '{2};
    run_stim();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule